// File: doc/BRIEF.md
# Request Descriptor Packetizer

This block turns one transfer request into the stream of 64-bit descriptors that a ring-based data engine consumes. A request names a number of source buffers and a number of destination buffers, plus a 16-bit request ID. The block reads each buffer's address and byte length from the requester's entry table through a lookup port. It checks every length first. It then writes header descriptors and buffer descriptors into consecutive slots of a circular descriptor ring.

A header goes in front of every group of up to 31 buffer descriptors. Two extension flags in the header mark the first and last group of a long request. Each buffer is encoded in one of two forms. If its length is a whole number of 16-byte units, it uses the "mega" form, which stores the length in 16-byte units. Otherwise it uses the normal form, which stores the byte length. The ring write pointer lives in the block and persists between requests. It passes over ring slots that hold link (next-pointer) descriptors, and it wraps at the end of the ring. When a request completes, a one-cycle pulse reports how many descriptors were written, so software can add that count to a doorbell.

Top module: `desc_packetizer`

## Requirements
- R1: After reset `busy`, `ring_we`, `done` and `reject` are 0, and `ring_rslot` is 0.
- R2: Bits 63:60 of every descriptor hold the 4-bit type code. The defaults are header=1, normal source=2, normal destination=3, mega source=4, mega destination=5, link=6.
- R3: A header is written before entry positions 0, 31, 62 and so on, as long as entries remain. Its count field at bits 40:36 equals the number of remaining entries, capped at 31.
- R4: A header has bit 56 (first) set only when it precedes entry 0. It has bit 57 (last) set only when 31 or fewer entries remain. Bits 31:16 are zero, bits 15:0 carry the request ID, and all other bits are zero.
- R5: Entries are read at table index `ent_idx`. Indices below the source count are sources and are written first. The remaining indices are destinations.
- R6: A length divisible by 16 is written in the mega form, with length/16 in bits 59:44. Any other length is written in the normal form, with the byte length in bits 59:44. The address occupies bits 43:0.
- R7: A request is rejected if any normal-form length exceeds 65535, or any mega-form length exceeds 65535*16. A rejected request produces a `reject` pulse, writes nothing, does not pulse `done`, and leaves the ring pointer unchanged.
- R8: After each write the ring pointer moves to the next slot, and from slot RING_SLOTS-1 it wraps to slot 0.
- R9: A slot whose type reads as link is never written. The pointer passes over such slots both before and after each write.
- R10: `done` pulses once per accepted request. `done_count` then equals the number of descriptors written, headers included. A request with no entries gives a pulse with a count of 0.
- R11: The ring pointer carries over from one request to the next, so each request continues where the previous one stopped.
- R12: `req_valid` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a request (accepted when idle) |
| req_nsrc | input | CNT_W | Number of source entries |
| req_ndst | input | CNT_W | Number of destination entries |
| req_id | input | 16 | Request ID written into headers |
| busy | output | 1 | Request in progress |
| ent_idx | output | TOT_W | Entry table index being read |
| ent_addr | input | ADDR_W | Buffer address at `ent_idx` (same cycle) |
| ent_len | input | LEN_W | Buffer byte length at `ent_idx` (same cycle) |
| ring_rslot | output | SLOT_W | Current ring pointer, used for type inspection |
| ring_rtype | input | 4 | Type field of the slot at `ring_rslot` (same cycle) |
| ring_we | output | 1 | Ring write strobe |
| ring_waddr | output | SLOT_W | Ring slot written |
| ring_wdata | output | 64 | Descriptor written |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | TOT_W+1 | Descriptors written for the finished request |
| reject | output | 1 | One-cycle pulse when a request fails the length check |

## Verification
The assertions assume three things about the inputs. `ent_addr` and `ent_len` follow `ent_idx` in the same cycle. `ring_rtype` reflects the current content of the slot at `ring_rslot`. The ring always holds at least one slot that is not a link. The bench meets all three. It serves the entry table and a 16-slot ring model combinationally, updates the ring model's type on every write, and places only three link slots (two of them adjacent), so the pointer always finds a writable slot. Request sizes are chosen around the 31-entry group boundary, and lengths sit exactly at and just past both encoding limits.

// File: rtl/pktz_pkg.sv
package pktz_pkg;
  localparam int DESC_W  = 64;
  localparam int SEG_MAX = 31;
  localparam int FLD_W   = 16;
  typedef logic [DESC_W-1:0] desc_t;
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_SEEK, ST_WRITE} pk_state_t;
endpackage

// File: rtl/pktz_enc.sv
module pktz_enc import pktz_pkg::*; #(
  parameter int ADDR_W = 44,
  parameter int LEN_W  = 21,
  parameter logic [3:0] TY_SRC  = 4'h2,
  parameter logic [3:0] TY_DST  = 4'h3,
  parameter logic [3:0] TY_MSRC = 4'h4,
  parameter logic [3:0] TY_MDST = 4'h5
) (
  input  logic              is_dst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output desc_t             desc,
  output logic              ok
);
  localparam logic [LEN_W-1:0] NORM_MAX = LEN_W'(65535);
  localparam logic [LEN_W-1:0] MEGA_MAX = LEN_W'(65535 * 16);

  logic            mega;
  logic [3:0]      ty;
  logic [FLD_W-1:0] fld;

  always_comb begin
    mega = (len[3:0] == 4'h0);
    ok   = mega ? (len <= MEGA_MAX) : (len <= NORM_MAX);
    fld  = mega ? len[4 +: FLD_W] : len[0 +: FLD_W];
    if (is_dst) ty = mega ? TY_MDST : TY_DST;
    else        ty = mega ? TY_MSRC : TY_SRC;
    desc = '0;
    desc[63:60] = ty;
    desc[59:44] = fld;
    desc[ADDR_W-1:0] = addr;
  end
endmodule

// File: rtl/pktz_hdr.sv
module pktz_hdr import pktz_pkg::*; #(
  parameter int TOT_W = 8,
  parameter logic [3:0] TY_HDR = 4'h1
) (
  input  logic [TOT_W-1:0] idx,
  input  logic [TOT_W-1:0] total,
  input  logic [15:0]      rid,
  output desc_t            desc
);
  logic [TOT_W-1:0] rem;
  logic             last;

  always_comb begin
    rem  = total - idx;
    last = (rem <= TOT_W'(SEG_MAX));
    desc = '0;
    desc[63:60] = TY_HDR;
    desc[57]    = last;
    desc[56]    = (idx == '0);
    desc[40:36] = last ? rem[4:0] : 5'(SEG_MAX);
    desc[15:0]  = rid;
  end
endmodule

// File: rtl/pktz_ptr.sv
module pktz_ptr #(
  parameter int SLOTS  = 64,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [SLOT_W-1:0] ptr
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    adv && ptr == LAST |=> ptr == '0);
  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv && ptr != LAST |=> ptr == $past(ptr) + 1'b1);
  // R11
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/desc_packetizer.sv
module desc_packetizer import pktz_pkg::*; #(
  parameter int MAX_ENT    = 127,
  parameter int RING_SLOTS = 64,
  parameter int ADDR_W     = 44,
  parameter int LEN_W      = 21,
  parameter logic [3:0] TY_HDR  = 4'h1,
  parameter logic [3:0] TY_SRC  = 4'h2,
  parameter logic [3:0] TY_DST  = 4'h3,
  parameter logic [3:0] TY_MSRC = 4'h4,
  parameter logic [3:0] TY_MDST = 4'h5,
  parameter logic [3:0] TY_NPTR = 4'h6,
  localparam int CNT_W  = $clog2(MAX_ENT + 1),
  localparam int TOT_W  = CNT_W + 1,
  localparam int SLOT_W = $clog2(RING_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CNT_W-1:0]  req_nsrc,
  input  logic [CNT_W-1:0]  req_ndst,
  input  logic [15:0]       req_id,
  output logic              busy,
  output logic [TOT_W-1:0]  ent_idx,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [LEN_W-1:0]  ent_len,
  output logic [SLOT_W-1:0] ring_rslot,
  input  logic [3:0]        ring_rtype,
  output logic              ring_we,
  output logic [SLOT_W-1:0] ring_waddr,
  output logic [63:0]       ring_wdata,
  output logic              done,
  output logic [TOT_W:0]    done_count,
  output logic              reject
);
  pk_state_t        state;
  logic [TOT_W-1:0] total, idx;
  logic [CNT_W-1:0] nsrc_r;
  logic [15:0]      rid;
  logic [4:0]       seg;
  logic             hdr_done;
  logic [TOT_W:0]   wcount;
  desc_t            enc_desc, hdr_desc;
  logic             enc_ok, need_hdr, ptr_adv, is_nptr;
  logic [TOT_W-1:0] req_total;

  pktz_enc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TY_SRC(TY_SRC), .TY_DST(TY_DST),
             .TY_MSRC(TY_MSRC), .TY_MDST(TY_MDST)) u_enc (
    .is_dst(idx >= TOT_W'(nsrc_r)), .addr(ent_addr), .len(ent_len),
    .desc(enc_desc), .ok(enc_ok));

  pktz_hdr #(.TOT_W(TOT_W), .TY_HDR(TY_HDR)) u_hdr (
    .idx(idx), .total(total), .rid(rid), .desc(hdr_desc));

  pktz_ptr #(.SLOTS(RING_SLOTS), .SLOT_W(SLOT_W)) u_ptr (
    .clk(clk), .rst(rst), .adv(ptr_adv), .ptr(ring_rslot));

  always_comb begin
    is_nptr   = (ring_rtype == TY_NPTR);
    need_hdr  = (seg == 5'd0) && !hdr_done;
    ptr_adv   = (state == ST_WRITE) || (state == ST_SEEK && is_nptr);
    req_total = TOT_W'(req_nsrc) + TOT_W'(req_ndst);
  end

  assign busy    = (state != ST_IDLE);
  assign ent_idx = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      total <= '0; idx <= '0; nsrc_r <= '0; rid <= '0;
      seg <= '0; hdr_done <= 1'b0; wcount <= '0;
      ring_we <= 1'b0; ring_waddr <= '0; ring_wdata <= '0;
      done <= 1'b0; done_count <= '0; reject <= 1'b0;
    end else begin
      ring_we <= 1'b0;
      done    <= 1'b0;
      reject  <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          total  <= req_total;
          nsrc_r <= req_nsrc;
          rid    <= req_id;
          idx    <= '0;
          if (req_total == '0) begin
            done       <= 1'b1;
            done_count <= '0;
          end else begin
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!enc_ok) begin
            reject <= 1'b1;
            state  <= ST_IDLE;
          end else if (TOT_W'(idx + 1'b1) == total) begin
            idx      <= '0;
            seg      <= '0;
            hdr_done <= 1'b0;
            wcount   <= '0;
            state    <= ST_SEEK;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_SEEK: if (!is_nptr) begin
          if (idx == total) begin
            done       <= 1'b1;
            done_count <= wcount;
            state      <= ST_IDLE;
          end else begin
            state <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          ring_we    <= 1'b1;
          ring_waddr <= ring_rslot;
          wcount     <= wcount + 1'b1;
          if (need_hdr) begin
            ring_wdata <= hdr_desc;
            hdr_done   <= 1'b1;
          end else begin
            ring_wdata <= enc_desc;
            idx        <= idx + 1'b1;
            hdr_done   <= 1'b0;
            seg        <= (seg == 5'(SEG_MAX - 1)) ? 5'd0 : seg + 1'b1;
          end
          state <= ST_SEEK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  nptr_skip_chk: assert property (@(posedge clk) disable iff (rst)
    ring_we |-> $past(ring_rtype) != TY_NPTR);
  // R3
  hdr_count_chk: assert property (@(posedge clk) disable iff (rst)
    ring_we && ring_wdata[63:60] == TY_HDR |-> ring_wdata[40:36] != 5'd0);
  // R6
  norm_len_chk: assert property (@(posedge clk) disable iff (rst)
    ring_we && (ring_wdata[63:60] == TY_SRC || ring_wdata[63:60] == TY_DST)
      |-> ring_wdata[47:44] != 4'h0);
  // R7
  reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    reject |-> !ring_we && !done);
endmodule

// File: tb/desc_packetizer_tb.sv
`timescale 1ns/1ps
module desc_packetizer_tb;
  localparam int SL = 16;
  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic req_valid = 1'b0;
  logic [6:0] req_nsrc = '0, req_ndst = '0;
  logic [15:0] req_id = '0;
  logic busy, ring_we, done, reject;
  logic [7:0] ent_idx;
  logic [43:0] ent_addr;
  logic [20:0] ent_len;
  logic [3:0] ring_rslot, ring_waddr, ring_rtype;
  logic [63:0] ring_wdata;
  logic [8:0] done_count;

  logic [43:0] tb_addr [256];
  logic [20:0] tb_len  [256];
  logic [3:0]  tb_type [SL];
  bit          nptr    [SL];

  assign ent_addr   = tb_addr[ent_idx];
  assign ent_len    = tb_len[ent_idx];
  assign ring_rtype = tb_type[ring_rslot];

  desc_packetizer #(.RING_SLOTS(SL)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_nsrc(req_nsrc),
    .req_ndst(req_ndst), .req_id(req_id), .busy(busy), .ent_idx(ent_idx),
    .ent_addr(ent_addr), .ent_len(ent_len), .ring_rslot(ring_rslot),
    .ring_rtype(ring_rtype), .ring_we(ring_we), .ring_waddr(ring_waddr),
    .ring_wdata(ring_wdata), .done(done), .done_count(done_count), .reject(reject));

  int checks = 0, errors = 0;
  int bptr = 0, exp_cnt = 0;
  bit done_seen = 0, reject_seen = 0, expect_bad = 0;
  logic [63:0] q_data [$];
  int          q_slot [$];
  string       q_tag  [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == SL - 1) ? 0 : p + 1;
  endfunction

  task automatic skip();
    while (nptr[bptr]) bptr = nxt(bptr);
  endtask

  task automatic push(input logic [63:0] d, input string tag);
    skip();
    q_data.push_back(d); q_slot.push_back(bptr); q_tag.push_back(tag);
    bptr = nxt(bptr);
    exp_cnt++;
  endtask

  // Reference stream per R2..R6
  task automatic build(input int ns, input int nd, input logic [15:0] id, output bit bad);
    int total = ns + nd;
    bad = 0;
    for (int i = 0; i < total; i++)
      if (tb_len[i] % 16 != 0 ? tb_len[i] > 65535 : tb_len[i] > 65535 * 16) bad = 1;
    exp_cnt = 0;
    if (bad) return;
    for (int i = 0; i < total; i++) begin
      logic [63:0] d;
      int rem, len;
      if (i % 31 == 0) begin
        rem = total - i;
        d = '0;
        d[63:60] = 4'h1;
        d[57] = (rem <= 31);
        d[56] = (i == 0);
        d[40:36] = 5'((rem <= 31) ? rem : 31);
        d[15:0] = id;
        push(d, "R3/R4 header");
      end
      len = int'(tb_len[i]);
      d = '0;
      if (len % 16 == 0) begin
        d[63:60] = (i < ns) ? 4'h4 : 4'h5;
        d[59:44] = 16'(len / 16);
      end else begin
        d[63:60] = (i < ns) ? 4'h2 : 4'h3;
        d[59:44] = 16'(len);
      end
      d[43:0] = tb_addr[i];
      push(d, "R5/R6 entry");
    end
    skip();
  endtask

  // Every-clock comparison against the reference queues
  always @(negedge clk) begin
    if (!rst) begin
      if (ring_we) begin
        tb_type[ring_waddr] = ring_wdata[63:60];
        if (q_data.size() == 0) chk(0, "R12/R9 unexpected write", ring_wdata, 0);
        else begin
          chk(ring_wdata == q_data[0], q_tag[0], ring_wdata, q_data[0]);
          chk(int'(ring_waddr) == q_slot[0], "R8/R9 slot", ring_waddr, q_slot[0]);
          void'(q_data.pop_front()); void'(q_slot.pop_front()); void'(q_tag.pop_front());
        end
      end
      if (done) begin
        done_seen = 1;
        chk(!expect_bad, "R7 done on bad request", 1, 0);
        chk(int'(done_count) == exp_cnt, "R10 done_count", done_count, exp_cnt);
      end
      if (reject) begin
        reject_seen = 1;
        chk(expect_bad, "R7 unexpected reject", 1, 0);
      end
    end
  end

  task automatic fill(input int seed, input int n);
    for (int i = 0; i < n; i++) begin
      tb_addr[i] = 44'(64'h0A5_0000_0000 + i * 4099 + seed);
      tb_len[i]  = (i % 3 == 0) ? 21'((i + seed + 1) * 16) : 21'(i * 7 + seed + 1);
      if (tb_len[i] % 16 == 0 && i % 3 != 0) tb_len[i] = tb_len[i] + 21'd1;
    end
  endtask

  task automatic run_req(input int ns, input int nd, input logic [15:0] id, input bit poke);
    bit bad;
    int start_ptr = bptr;
    build(ns, nd, id, bad);
    expect_bad = bad;
    done_seen = 0; reject_seen = 0;
    @(negedge clk);
    req_valid = 1; req_nsrc = 7'(ns); req_ndst = 7'(nd); req_id = id;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1; req_nsrc = 7'd2; req_ndst = 7'd1; req_id = 16'hDEAD;
      @(negedge clk);
      req_valid = 0;
    end
    while (!(done_seen || reject_seen)) @(posedge clk);
    repeat (6) @(negedge clk);
    if (bad) begin
      chk(reject_seen, "R7 reject pulse", reject_seen, 1);
      chk(int'(ring_rslot) == start_ptr, "R7 pointer unchanged", ring_rslot, start_ptr);
    end else begin
      chk(done_seen, "R10 done pulse", done_seen, 1);
      chk(q_data.size() == 0, "R10 all descriptors written", q_data.size(), 0);
      chk(int'(ring_rslot) == bptr, "R11 pointer carried", ring_rslot, bptr);
    end
    chk(!busy, "R12 idle after request", busy, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < SL; i++) begin tb_type[i] = 4'h0; nptr[i] = 0; end
    nptr[3] = 1; nptr[4] = 1; nptr[10] = 1;
    tb_type[3] = 4'h6; tb_type[4] = 4'h6; tb_type[10] = 4'h6;
    fill(0, 200);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !ring_we && !done && !reject, "R1 reset outputs", {busy, ring_we, done, reject}, 0);
    chk(ring_rslot == 0, "R1 reset pointer", ring_rslot, 0);

    // R6 small request, normal source and mega destination
    tb_len[0] = 21'd100; tb_len[1] = 21'd64;
    run_req(1, 1, 16'h1234, 0);
    // R3/R4 exactly 31 entries: one header with both flags
    fill(3, 200);
    run_req(20, 11, 16'h0031, 0);
    // R3/R4 32 entries: two headers
    run_req(12, 20, 16'h0032, 0);
    // R3 62 and 63 entries, R8 wrap over many passes
    fill(5, 200);
    run_req(40, 22, 16'h0062, 0);
    run_req(30, 33, 16'h0063, 0);
    // R10 zero entries
    run_req(0, 0, 16'h0000, 0);
    // R6/R7 boundary lengths that are accepted
    fill(9, 200);
    tb_len[0] = 21'd65535; tb_len[1] = 21'd1048560; tb_len[2] = 21'd0;
    run_req(2, 2, 16'hB0B0, 0);
    // R7 normal length past limit
    tb_len[1] = 21'd65537;
    run_req(1, 2, 16'hBAD1, 0);
    // R7 mega length past limit
    tb_len[1] = 21'd1048576;
    run_req(3, 0, 16'hBAD2, 0);
    // R12 req_valid during busy ignored, R5 destinations only
    fill(11, 200);
    run_req(0, 70, 16'h7070, 1);
    run_req(70, 0, 16'h7071, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule